// File: doc/BRIEF.md
# Program Status Word Flag Unit

This block keeps a 32-bit processor status word. Its top four bits are the condition flags: negative, zero, carry and overflow. Its low byte holds the control state: a five-bit operating mode, an instruction-set state bit and two interrupt-disable bits. The bits in between always read as zero. An execute stage sends the flag inputs every cycle: the 32-bit result, the adder carry-out, the shifter carry-out, a signed-overflow indication, an update enable and an arithmetic/logical select. When updates are enabled, the unit recomputes the flags from those inputs. System software can also write the whole word through a write port, and a privilege input decides how much of that write takes effect.

Each cycle a decoder picks one of four named update states. UPD_IDLE holds everything. UPD_FLAGS loads the computed flags. UPD_USER_WR loads only the flag nibble from write data. UPD_PRIV_WR loads the flag nibble and the control byte from write data. The selection is made again on every clock edge, with no stored history. Any state can follow any other, depending only on that cycle's write enable, privilege and update enable. A write has priority over a flag update. Every change shows on the output one clock edge after the inputs are sampled.

Top module: `psr_flag_unit`

## Requirements
- R1: After reset the output word is 0x000000D3: all flags 0, interrupt-disable bits at positions 7 and 6 set to 1, state bit 5 cleared, mode field [4:0] = 5'b10011.
- R2: With an update enabled and no write, bit 31 becomes bit 31 of the result one cycle later.
- R3: With an update enabled and no write, bit 30 becomes 1 exactly when all 32 result bits are zero.
- R4: With an update enabled and no write, bit 29 takes the adder carry-out when arithmetic is selected (select = 1) and the shifter carry-out when logical is selected (select = 0).
- R5: With an update enabled and no write, bit 28 takes the overflow input for an arithmetic operation and keeps its old value for a logical operation.
- R6: With neither an update nor a write, bits 31:28 keep their values.
- R7: A write with privilege low loads bits 31:28 from write data and leaves bits 7:0 unchanged.
- R8: A write with privilege high loads bits 31:28 and 7:0 from write data.
- R9: Bits 27:8 of the output always read zero, whatever is written.
- R10: When a write and a flag update occur in the same cycle, only the write takes effect.
- R11: With privilege low, bits 7:0 never change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_i | input | 32 | Result used for flag computation |
| add_cout_i | input | 1 | Adder carry-out |
| shf_cout_i | input | 1 | Shifter carry-out |
| ovf_i | input | 1 | Signed overflow into the sign bit |
| upd_en_i | input | 1 | Update flags from this cycle's result |
| arith_i | input | 1 | 1 = arithmetic operation, 0 = logical |
| priv_i | input | 1 | Core is in a privileged mode |
| wr_en_i | input | 1 | Write the status word |
| wr_data_i | input | 32 | Write data |
| psr_o | output | 32 | Current status word |

## Verification
The flag computation is tried with a negative arithmetic result that has both carry and overflow, and with an all-zero arithmetic result. It is also tried with a logical zero result after overflow has been set, which shows whether the carry comes from the adder or the shifter and whether overflow is held. Cycles that drive a result without enabling an update check that the flags hold. All-ones writes made without privilege check that only the flag nibble can change. Privileged writes with mixed patterns in the middle bits check that the control byte loads and that the unused bits stay zero. A cycle with both a privileged write and a flag update checks that the write wins.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int PSR_W  = 32;
    localparam int FLAG_W = 4;
    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {
        UPD_IDLE    = 2'd0,
        UPD_FLAGS   = 2'd1,
        UPD_USER_WR = 2'd2,
        UPD_PRIV_WR = 2'd3
    } upd_sel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;
endpackage

// File: rtl/psr_flag_calc.sv
module psr_flag_calc #(
    parameter int RES_W = 32
) (
    input  logic [RES_W-1:0]    res_i,
    input  logic                add_cout_i,
    input  logic                shf_cout_i,
    input  logic                ovf_i,
    input  logic                arith_i,
    input  psr_pkg::flags_t     flags_q_i,
    output psr_pkg::flags_t     flags_nxt_o
);
    always_comb begin
        flags_nxt_o.n = res_i[RES_W-1];
        flags_nxt_o.z = (res_i == '0);
        if (arith_i) begin
            flags_nxt_o.c = add_cout_i;
            flags_nxt_o.v = ovf_i;
        end else begin
            flags_nxt_o.c = shf_cout_i;
            flags_nxt_o.v = flags_q_i.v;
        end
    end
endmodule

// File: rtl/psr_upd_decode.sv
module psr_upd_decode (
    input  logic               upd_en_i,
    input  logic               wr_en_i,
    input  logic               priv_i,
    output psr_pkg::upd_sel_e  sel_o
);
    always_comb begin
        if (wr_en_i && priv_i)
            sel_o = psr_pkg::UPD_PRIV_WR;
        else if (wr_en_i)
            sel_o = psr_pkg::UPD_USER_WR;
        else if (upd_en_i)
            sel_o = psr_pkg::UPD_FLAGS;
        else
            sel_o = psr_pkg::UPD_IDLE;
    end
endmodule

// File: rtl/psr_write_guard.sv
module psr_write_guard #(
    parameter int CTRL_W = 8
) (
    input  psr_pkg::upd_sel_e  sel_i,
    input  psr_pkg::flags_t    flags_q_i,
    input  psr_pkg::flags_t    flags_calc_i,
    input  logic [3:0]         wr_flags_i,
    input  logic [CTRL_W-1:0]  ctrl_q_i,
    input  logic [CTRL_W-1:0]  wr_ctrl_i,
    output psr_pkg::flags_t    flags_d_o,
    output logic [CTRL_W-1:0]  ctrl_d_o
);
    always_comb begin
        flags_d_o = flags_q_i;
        ctrl_d_o  = ctrl_q_i;
        unique case (sel_i)
            psr_pkg::UPD_IDLE: begin
                flags_d_o = flags_q_i;
            end
            psr_pkg::UPD_FLAGS: begin
                flags_d_o = flags_calc_i;
            end
            psr_pkg::UPD_USER_WR: begin
                flags_d_o = psr_pkg::flags_t'(wr_flags_i);
            end
            psr_pkg::UPD_PRIV_WR: begin
                flags_d_o = psr_pkg::flags_t'(wr_flags_i);
                ctrl_d_o  = wr_ctrl_i;
            end
            default: begin
                flags_d_o = flags_q_i;
            end
        endcase
    end
endmodule

// File: rtl/psr_flag_unit.sv
module psr_flag_unit #(
    parameter int         PSR_W      = psr_pkg::PSR_W,
    parameter int         CTRL_W     = psr_pkg::CTRL_W,
    parameter logic [7:0] RESET_CTRL = 8'hD3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSR_W-1:0] res_i,
    input  logic             add_cout_i,
    input  logic             shf_cout_i,
    input  logic             ovf_i,
    input  logic             upd_en_i,
    input  logic             arith_i,
    input  logic             priv_i,
    input  logic             wr_en_i,
    input  logic [PSR_W-1:0] wr_data_i,
    output logic [PSR_W-1:0] psr_o
);
    localparam int FLAG_W = psr_pkg::FLAG_W;
    localparam int MID_W  = PSR_W - FLAG_W - CTRL_W;

    psr_pkg::flags_t   flags_q, flags_d, flags_calc;
    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    psr_pkg::upd_sel_e sel;
    logic              mid_unused;

    assign mid_unused = ^wr_data_i[PSR_W-FLAG_W-1:CTRL_W];

    psr_flag_calc #(.RES_W(PSR_W)) calc_i (
        .res_i       (res_i),
        .add_cout_i  (add_cout_i),
        .shf_cout_i  (shf_cout_i),
        .ovf_i       (ovf_i),
        .arith_i     (arith_i),
        .flags_q_i   (flags_q),
        .flags_nxt_o (flags_calc)
    );

    psr_upd_decode dec_i (
        .upd_en_i (upd_en_i),
        .wr_en_i  (wr_en_i),
        .priv_i   (priv_i),
        .sel_o    (sel)
    );

    psr_write_guard #(.CTRL_W(CTRL_W)) guard_i (
        .sel_i        (sel),
        .flags_q_i    (flags_q),
        .flags_calc_i (flags_calc),
        .wr_flags_i   (wr_data_i[PSR_W-1:PSR_W-FLAG_W]),
        .ctrl_q_i     (ctrl_q),
        .wr_ctrl_i    (wr_data_i[CTRL_W-1:0]),
        .flags_d_o    (flags_d),
        .ctrl_d_o     (ctrl_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            ctrl_q  <= RESET_CTRL[CTRL_W-1:0];
        end else begin
            flags_q <= flags_d;
            ctrl_q  <= ctrl_d;
        end
    end

    always_comb begin
        psr_o = {flags_q, {MID_W{1'b0}}, ctrl_q};
    end
endmodule

// File: rtl/psr_flag_unit_chk.sv
module psr_flag_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] res_i,
    input logic        upd_en_i,
    input logic        arith_i,
    input logic        priv_i,
    input logic        wr_en_i,
    input logic [3:0]  wr_flags,
    input logic [7:0]  wr_ctrl,
    input logic [31:0] psr_o
);
    // R2
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && !wr_en_i) |=> (psr_o[31] == $past(res_i[31])));

    // R3
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && !wr_en_i) |=> (psr_o[30] == ($past(res_i) == 32'd0)));

    // R5
    v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && !arith_i && !wr_en_i) |=> $stable(psr_o[28]));

    // R6
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en_i && !wr_en_i) |=> $stable(psr_o[31:28]));

    // R7
    user_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !priv_i) |=> (psr_o[31:28] == $past(wr_flags)));

    // R8
    priv_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && priv_i) |=> (psr_o[7:0] == $past(wr_ctrl)));

    // R9
    mid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psr_o[27:8] == 20'd0);

    // R11
    ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !priv_i |=> $stable(psr_o[7:0]));
endmodule

bind psr_flag_unit psr_flag_unit_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_i    (res_i),
    .upd_en_i (upd_en_i),
    .arith_i  (arith_i),
    .priv_i   (priv_i),
    .wr_en_i  (wr_en_i),
    .wr_flags (wr_data_i[31:28]),
    .wr_ctrl  (wr_data_i[7:0]),
    .psr_o    (psr_o)
);

// File: tb/psr_flag_unit_tb_top.sv
`timescale 1ns/1ps
module psr_flag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] res_i = '0;
    logic        add_cout_i = 1'b0;
    logic        shf_cout_i = 1'b0;
    logic        ovf_i = 1'b0;
    logic        upd_en_i = 1'b0;
    logic        arith_i = 1'b0;
    logic        priv_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] psr_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    psr_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .res_i(res_i), .add_cout_i(add_cout_i),
        .shf_cout_i(shf_cout_i), .ovf_i(ovf_i), .upd_en_i(upd_en_i),
        .arith_i(arith_i), .priv_i(priv_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .psr_o(psr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        upd_en_i = 1'b0; wr_en_i = 1'b0; priv_i = 1'b0;
        res_i = '0; add_cout_i = 1'b0; shf_cout_i = 1'b0; ovf_i = 1'b0; arith_i = 1'b0;
        wr_data_i = '0;
    endtask

    task automatic flag_op(input logic [31:0] r, input logic ar, input logic ac,
                           input logic sc, input logic ov, input logic en);
        res_i = r; arith_i = ar; add_cout_i = ac; shf_cout_i = sc; ovf_i = ov;
        upd_en_i = en;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic write_op(input logic [31:0] d, input logic pv);
        wr_data_i = d; priv_i = pv; wr_en_i = 1'b1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle_inputs();
        @(negedge clk);
        chk("R1 reset word", psr_o, 32'h000000D3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 held after release", psr_o, 32'h000000D3);
    endtask

    task automatic t_arith_neg();
        flag_op(32'h8000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R2 N from bit31", {31'd0, psr_o[31]}, 32'd1);
        chk("R4 C from adder", {31'd0, psr_o[29]}, 32'd1);
        chk("R5 V from overflow", {31'd0, psr_o[28]}, 32'd1);
        chk("R2 word", psr_o, 32'hB00000D3);
    endtask

    task automatic t_arith_zero();
        flag_op(32'h0000_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R3 Z on zero result", psr_o, 32'h400000D3);
    endtask

    task automatic t_logical();
        flag_op(32'h0000_0001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R3 nonzero clears Z", psr_o, 32'h100000D3);
        flag_op(32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R4 C from shifter", {31'd0, psr_o[29]}, 32'd1);
        chk("R5 V held on logical", psr_o, 32'h700000D3);
    endtask

    task automatic t_hold();
        flag_op(32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 flags hold without update", psr_o, 32'h700000D3);
    endtask

    task automatic t_user_write();
        write_op(32'hFFFF_FFFF, 1'b0);
        chk("R7 user write flags only", psr_o, 32'hF00000D3);
        chk("R11 ctrl unchanged unprivileged", {24'd0, psr_o[7:0]}, 32'h000000D3);
        chk("R9 mid zero after user write", {12'd0, psr_o[27:8]}, 32'd0);
    endtask

    task automatic t_priv_write();
        write_op(32'h5ABC_DE10, 1'b1);
        chk("R8 privileged write", psr_o, 32'h50000010);
        chk("R9 mid zero after priv write", {12'd0, psr_o[27:8]}, 32'd0);
        write_op(32'hAFFF_FFEF, 1'b0);
        chk("R7 user write in user mode", psr_o, 32'hA0000010);
    endtask

    task automatic t_precedence();
        res_i = 32'h8000_0000; arith_i = 1'b1; add_cout_i = 1'b1; ovf_i = 1'b1;
        upd_en_i = 1'b1;
        write_op(32'h0000_0013, 1'b1);
        chk("R10 write beats update", psr_o, 32'h00000013);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 10000) begin
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected<=10000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        idle_inputs();
        @(negedge clk);
        t_reset();
        t_arith_neg();
        t_arith_zero();
        t_logical();
        t_hold();
        t_user_write();
        t_priv_write();
        t_precedence();
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule